// File: doc/BRIEF.md
# Two-Level Address Translation Unit with TLB

This block turns a 32-bit virtual address into a physical address for 4 KB pages. It first checks a small fully associative translation cache. On a hit, the physical address is returned one cycle after the request is accepted, and memory is not touched. On a miss, a hardware walker reads two table words in turn through a single-word memory read port. The first read comes from the top-level table, whose base comes from the table-base input. The second read comes from the leaf table that the first word points to. The walker then either installs the leaf mapping in the cache and returns the translation, or reports a fault.

Each table word has the same layout. Bits 31:12 hold the next physical frame, bit 2 allows stores, bit 1 allows user-mode access, and bit 0 marks the word as present. A flush input clears the whole cache. The requester issues one translation at a time with a ready/valid pair and receives a one-cycle response pulse.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: The first read of a walk is at `{ptbr[31:12], vaddr[31:22], 2'b00}`.
- R3: The second read is at `{first_word[31:12], vaddr[21:12], 2'b00}`.
- R4: A successful walk responds with `resp_fault`=0 and `resp_paddr = {leaf[31:12], vaddr[11:0]}`, and it installs the mapping in the cache.
- R5: A cache hit responds in the cycle after acceptance with no memory read. It gives the same physical address as the walk did.
- R6: A first or second word with bit 0 clear ends the walk with `resp_fault`=1 and `resp_paddr`=0. Nothing is installed, so a repeat request walks again. A bad first word costs exactly one read.
- R7: A store to a page whose bit 2 is clear, or a user access to a page whose bit 1 is clear, faults. This holds whether the mapping comes from a walk or from a hit. A faulting walk installs nothing.
- R8: The cache holds 8 entries and replaces them in round-robin order. The ninth distinct install evicts the oldest one and keeps the rest.
- R9: A one-cycle `flush` pulse invalidates every entry, so every page walks again.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. The read data is taken in the cycle of `mem_ack`. A walk makes at most two reads.
- R11: `req_ready` is 0 while a walk is in progress. A request presented then is ignored and produces neither a response nor a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | Access is a store |
| req_user | input | 1 | Access is from user mode |
| ptbr | input | 32 | Physical base of the top-level table |
| flush | input | 1 | Invalidate all cache entries |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Translation fault |
| resp_paddr | output | 32 | Physical address (0 on fault) |

## Verification
The bench sends cold misses, repeat hits, stores and user accesses against pages with different permission bits, a missing leaf word, and a missing top-level word. It does this under memory latencies of zero to three cycles. Comparing read counts separates a hit, a one-read fault and a two-read walk. Repeating a faulting request shows whether anything was installed. A flush followed by nine distinct pages shows the round-robin eviction order, because the oldest page walks while the second-oldest still hits. Requests held during a walk test that a busy unit drops them.

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker #(
  parameter int TLB_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_store,
  input  logic        req_user,
  input  logic [31:0] ptbr,
  input  logic        flush,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [31:0] resp_paddr
);
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_TOP, S_LEAF} st_t;
  st_t st;

  logic [TLB_N-1:0] t_v, t_w, t_u;
  logic [19:0]      t_vpn [TLB_N];
  logic [19:0]      t_ppn [TLB_N];
  logic [IW-1:0]    vic;

  logic [31:0] va_q;
  logic        store_q, user_q;
  logic [19:0] base_q;

  logic          hit;
  logic [IW-1:0] hidx;

  function automatic logic denied(input logic s, input logic u, input logic w_ok, input logic u_ok);
    return (s & ~w_ok) | (u & ~u_ok);
  endfunction

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_v[i] && t_vpn[i] == req_vaddr[31:12]) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_addr  = (st == S_TOP) ? {base_q, va_q[31:22], 2'b00}
                                   : {base_q, va_q[21:12], 2'b00};

  wire hit_bad  = denied(req_store, req_user, t_w[hidx], t_u[hidx]);
  wire leaf_bad = ~mem_rdata[0] | denied(store_q, user_q, mem_rdata[2], mem_rdata[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      t_v        <= '0;
      t_w        <= '0;
      t_u        <= '0;
      vic        <= '0;
      va_q       <= '0;
      store_q    <= 1'b0;
      user_q     <= 1'b0;
      base_q     <= '0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (flush) t_v <= '0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_fault <= hit_bad;
            resp_paddr <= hit_bad ? 32'd0 : {t_ppn[hidx], req_vaddr[11:0]};
          end else begin
            va_q    <= req_vaddr;
            store_q <= req_store;
            user_q  <= req_user;
            base_q  <= ptbr[31:12];
            st      <= S_TOP;
          end
        end
        S_TOP: if (mem_ack) begin
          if (!mem_rdata[0]) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            st         <= S_IDLE;
          end else begin
            base_q <= mem_rdata[31:12];
            st     <= S_LEAF;
          end
        end
        S_LEAF: if (mem_ack) begin
          resp_valid <= 1'b1;
          resp_fault <= leaf_bad;
          resp_paddr <= leaf_bad ? 32'd0 : {mem_rdata[31:12], va_q[11:0]};
          if (!leaf_bad) begin
            t_v[vic]   <= 1'b1;
            t_w[vic]   <= mem_rdata[2];
            t_u[vic]   <= mem_rdata[1];
            t_vpn[vic] <= va_q[31:12];
            t_ppn[vic] <= mem_rdata[31:12];
            vic        <= (vic == IW'(TLB_N - 1)) ? '0 : vic + 1'b1;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
`timescale 1ns/1ps
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic [31:0] ptbr,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic [31:0] resp_paddr
);
  logic [11:0] off_q;
  logic [9:0]  top_idx_q;
  logic [19:0] base_q;
  logic        second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= '0;
      top_idx_q <= '0;
      base_q    <= '0;
      second_q  <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_q     <= req_vaddr[11:0];
      top_idx_q <= req_vaddr[31:22];
      base_q    <= ptbr[31:12];
      second_q  <= 1'b0;
    end else if (mem_req && mem_ack) begin
      second_q  <= 1'b1;
    end
  end

  a_r2_top_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !second_q |-> mem_addr == {base_q, top_idx_q, 2'b00});

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == 32'd0);

  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[11:0] == off_q);

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r5_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !mem_req);
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_tb.sv
`timescale 1ns/1ps
module xlat_walker_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, req_user = 0, flush = 0;
  logic [31:0] req_vaddr = 0, ptbr = 32'h0001_0000;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic req_ready, mem_req, resp_valid, resp_fault;
  logic [31:0] mem_addr, resp_paddr;

  always #2 clk = ~clk;

  xlat_walker u_dut (.*);

  typedef struct { logic [19:0] vpn; logic [19:0] ppn; bit w; bit u; } ent_t;
  ent_t tq[$];
  logic [31:0] eq[$];
  bit [31:0] pmem [bit [31:0]];
  int checks = 0, errors = 0, rd_cnt = 0, lat = 0, wcnt = 0;
  logic [31:0] hold_addr;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] vad(input int pg, input logic [11:0] off);
    return {10'd1, 10'(pg), off};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt > 0) chk(mem_addr == hold_addr, "R10 addr stable", mem_addr, hold_addr);
      hold_addr = mem_addr;
      if (wcnt >= lat) begin
        mem_ack   = 1;
        mem_rdata = rd(mem_addr);
        rd_cnt++;
        wcnt = 0;
        if (eq.size() == 0) chk(0, "R10 unexpected read", mem_addr, 0);
        else begin
          logic [31:0] e;
          e = eq.pop_front();
          chk(mem_addr == e, "R2/R3 read address", mem_addr, e);
        end
      end else wcnt++;
    end else begin
      mem_ack = 0;
      wcnt = 0;
    end
  end

  task automatic xlate(input int pg, input logic [11:0] off, input bit st, input bit us, input int l, input string tag);
    logic [31:0] va, w1, w2, exp_pa;
    bit exp_f, is_hit;
    int exp_rd, n, hi;
    va = vad(pg, off);
    lat = l;
    is_hit = 0; hi = 0;
    foreach (tq[i]) if (tq[i].vpn == va[31:12]) begin is_hit = 1; hi = i; end
    exp_pa = 0; exp_f = 0; exp_rd = 0;
    if (is_hit) begin
      exp_f = (st && !tq[hi].w) || (us && !tq[hi].u);
      if (!exp_f) exp_pa = {tq[hi].ppn, off};
    end else begin
      eq.push_back({ptbr[31:12], va[31:22], 2'b00});
      w1 = rd({ptbr[31:12], va[31:22], 2'b00});
      exp_rd = 1;
      if (!w1[0]) exp_f = 1;
      else begin
        eq.push_back({w1[31:12], va[21:12], 2'b00});
        w2 = rd({w1[31:12], va[21:12], 2'b00});
        exp_rd = 2;
        exp_f = !w2[0] || (st && !w2[2]) || (us && !w2[1]);
        if (!exp_f) begin
          ent_t e;
          exp_pa = {w2[31:12], off};
          e.vpn = va[31:12]; e.ppn = w2[31:12]; e.w = w2[2]; e.u = w2[1];
          if (tq.size() == 8) void'(tq.pop_front());
          tq.push_back(e);
        end
      end
    end
    rd_cnt = 0;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    req_valid = 1; req_vaddr = va; req_store = st; req_user = us;
    @(negedge clk);
    if (is_hit) begin
      req_valid = 0;
      chk(resp_valid == 1, {"R5 hit latency ", tag}, resp_valid, 1);
    end else begin
      chk(req_ready == 0, {"R11 busy during walk ", tag}, req_ready, 0);
      req_vaddr = 32'hFFFF_F123; req_store = 0; req_user = 0;
      n = 0;
      while (!resp_valid && n < 100) begin @(negedge clk); n++; end
      req_valid = 0;
      chk(resp_valid == 1, {"R10 walk responds ", tag}, resp_valid, 1);
    end
    chk(resp_fault == exp_f, {"R4/R6/R7 fault ", tag}, resp_fault, exp_f);
    chk(resp_paddr == exp_pa, {"R4/R5 paddr ", tag}, resp_paddr, exp_pa);
    chk(rd_cnt == exp_rd, {"R5/R6/R10 read count ", tag}, rd_cnt, exp_rd);
    @(negedge clk);
    chk(!resp_valid && !mem_req, {"R11 stray request ignored ", tag}, {resp_valid, mem_req}, 0);
    chk(eq.size() == 0, {"R10 reads missing ", tag}, eq.size(), 0);
    eq.delete();
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    tq.delete();
  endtask

  initial begin
    pmem[ptbr + 4] = 32'h0002_0001;
    for (int i = 0; i < 13; i++) begin
      logic [2:0] fl;
      fl = (i < 10) ? 3'b111 : (i == 10) ? 3'b011 : (i == 11) ? 3'b101 : 3'b000;
      pmem[32'h0002_0000 + 4*i] = {20'h00100 + 20'(i), 9'd0, fl};
    end
    #1;
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R1 reset state", {req_ready, resp_valid, mem_req}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R1 after reset", {req_ready, resp_valid, mem_req}, 3'b100);

    xlate(0, 12'hABC, 0, 0, 0, "R2 R3 R4 cold miss");
    xlate(0, 12'h123, 0, 0, 0, "R5 hit");
    xlate(0, 12'h004, 1, 1, 0, "R5 hit store user");
    xlate(10, 12'h010, 1, 0, 2, "R7 store ro walk");
    xlate(10, 12'h010, 1, 0, 1, "R7 no fill rewalk");
    xlate(10, 12'h020, 0, 0, 3, "R4 ro load fill");
    xlate(10, 12'h030, 1, 0, 0, "R7 store ro hit");
    xlate(11, 12'h040, 0, 1, 2, "R7 user walk");
    xlate(11, 12'h050, 0, 0, 0, "R4 kernel fill");
    xlate(11, 12'h060, 0, 1, 0, "R7 user hit");
    xlate(12, 12'h070, 0, 0, 1, "R6 leaf invalid");
    xlate(12, 12'h070, 0, 0, 0, "R6 leaf rewalk");
    req_vaddr = 0;
    begin
      logic [31:0] v2;
      v2 = 32'h0080_5555;
      eq.push_back({ptbr[31:12], v2[31:22], 2'b00});
      rd_cnt = 0;
      @(negedge clk); req_valid = 1; req_vaddr = v2; req_store = 0; req_user = 0;
      @(negedge clk); req_valid = 0;
      while (!resp_valid) @(negedge clk);
      chk(resp_fault == 1 && resp_paddr == 0, "R6 top invalid", {resp_fault, resp_paddr[30:0]}, 32'h8000_0000);
      chk(rd_cnt == 1, "R6 top invalid one read", rd_cnt, 1);
    end
    do_flush();
    xlate(0, 12'h111, 0, 0, 2, "R9 flush rewalk");
    for (int p = 1; p < 9; p++) xlate(p, 12'h200, 0, 0, p % 3, "R8 fill");
    xlate(1, 12'h300, 0, 0, 0, "R8 second oldest kept");
    xlate(0, 12'h400, 0, 0, 1, "R8 oldest evicted");
    xlate(8, 12'h500, 0, 0, 0, "R8 newest kept");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule